// File: doc/BRIEF.md
# Infrared Pulse-Width Symbol Capture

This block watches the demodulated output of an infrared receiver and measures the line one phase at a time. Each burst on the line is a run of pulse/space pairs. The block times every pulse and every space in coarse units and packs each pair into one 32-bit symbol word. A downstream queue and a software or hardware protocol decoder consume these words. The time base comes from a programmable prescaler that turns the system clock into a 1 µs tick. A second divider groups these ticks into measurement units of `UNIT_US` microseconds, 10 µs by default.

Capture follows a fixed order. The block is enabled, its busy period runs out, and then a start strobe arms it while raw mode is selected. After that it waits for the line to rest at its idle level, and then for the first pulse. A symbol is emitted when the next pulse begins. A space that grows until pulse plus space reaches the programmed maximum width ends the burst. That final symbol goes out with the space clipped so that the sum equals the maximum, and a timeout pulse marks it. A typical maximum is 16000 units (160 ms). The pulse counter also stops at the maximum, so a line stuck at the pulse level still yields a bounded symbol.

Top module: `ir_symbol_capture`

## Requirements
- R1: One measurement unit lasts (cfg_prescale_i + 1) * UNIT_US clock cycles. A phase lasting L clock cycles, with L not a multiple of the unit, is reported as floor(L / unit) units.
- R2: In each symbol word, bits [15:0] hold the pulse width and bits [31:16] hold the space width, both in units.
- R3: cfg_format_i, latched at the start strobe, selects the line polarity. With 0 the line idles high and a pulse is low. With 1 the line idles low and a pulse is high.
- R4: When a pulse begins after a space, the block emits the preceding pulse/space pair with timeout_o low.
- R5: When pulse plus space reaches cfg_max_width_i during a space, the block emits the symbol with space = max − pulse and timeout_o high in the same cycle. It then waits for the next pulse without needing a new start.
- R6: The pulse count saturates at cfg_max_width_i. A pulse longer than the maximum produces the word {0, max} with timeout_o high.
- R7: After cfg_enable_i rises, busy_o is high for exactly BUSY_CYCLES cycles (8 by default). A start strobe given while busy is ignored.
- R8: No symbol is emitted until a start strobe arrives with cfg_raw_mode_i high. A start strobe with raw mode low is ignored.
- R9: With cfg_enable_i low, busy_o and sym_valid_o are low from the next cycle on, and any capture in progress is dropped.
- R10: If the line is at the pulse level when the start strobe arrives, that partial pulse is not measured. Capture begins with the first pulse after the line has returned to idle.
- R11: sym_valid_o is high for a single cycle per symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable_i | input | 1 | Block enable; low holds the block off |
| cfg_raw_mode_i | input | 1 | Raw capture selected; needed for a start strobe to be accepted |
| cfg_format_i | input | 1 | Line polarity: 0 idle high, 1 idle low |
| cfg_prescale_i | input | PRESCALE_W | Clock frequency in MHz minus one |
| cfg_max_width_i | input | 16 | Maximum pulse plus space, in units |
| start_i | input | 1 | One-cycle strobe that arms capture |
| ir_in_i | input | 1 | Asynchronous receiver line |
| busy_o | output | 1 | High while internal state settles after enable |
| sym_valid_o | output | 1 | One-cycle strobe with a new symbol word |
| sym_word_o | output | 32 | {space width, pulse width} |
| timeout_o | output | 1 | Marks the final symbol of a burst |

## Verification
The hardest cases to reach are the ones where a phase lands right on the maximum width. These are the saturated pulse that turns into a zero-width timeout space, and a burst that is armed while the line already sits at the pulse level. Directed sequences hold the line low well past the maximum, and raise the start strobe in the middle of a pulse, under both polarities. Around these, random bursts with a fixed seed vary the prescaler and the pulse and space widths. Each phase length is set half a unit away from a unit boundary, so the expected count in each word is exact.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

   localparam int CNT_W = 16;

   typedef logic [CNT_W-1:0] cnt_t;

   typedef struct packed {
      cnt_t space;
      cnt_t mark;
   } sym_word_t;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_BUSY,
      ST_READY,
      ST_WAIT_IDLE,
      ST_WAIT_PULSE,
      ST_MARK,
      ST_SPACE
   } cap_state_e;

   // saturating subtraction used for the clipped space on a timeout
   function automatic cnt_t sat_sub(input cnt_t a, input cnt_t b);
      return (a > b) ? cnt_t'(a - b) : '0;
   endfunction

endpackage

// File: rtl/ir_cap_sync.sv
module ir_cap_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ir_cap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/ir_cap_timebase.sv
module ir_cap_timebase #(
   parameter int PRESCALE_W = 7,
   parameter int UNIT_US    = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run_i,
   input  logic                  restart_i,
   input  logic [PRESCALE_W-1:0] prescale_i,
   output logic                  unit_tick_o
);

   localparam int DEC_W = (UNIT_US > 1) ? $clog2(UNIT_US) : 1;

   if (PRESCALE_W < 1 || PRESCALE_W > 16) begin : g_bad_pw
      $error("ir_cap_timebase: PRESCALE_W out of range");
   end
   if (UNIT_US < 1) begin : g_bad_unit
      $error("ir_cap_timebase: UNIT_US must be positive");
   end

   logic [PRESCALE_W-1:0] pre_cnt;
   logic                  us_tick;

   // >= keeps the divider bounded if the prescale value drops mid-count
   assign us_tick = run_i && (pre_cnt >= prescale_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pre_cnt <= '0;
      else if (restart_i || !run_i) pre_cnt <= '0;
      else if (us_tick)             pre_cnt <= '0;
      else                          pre_cnt <= pre_cnt + 1'b1;
   end

   if (UNIT_US == 1) begin : g_unit_direct
      assign unit_tick_o = us_tick;
   end else begin : g_unit_divided
      logic [DEC_W-1:0] dec_cnt;
      logic             dec_last;

      assign dec_last    = (dec_cnt == DEC_W'(UNIT_US - 1));
      assign unit_tick_o = us_tick && dec_last;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   dec_cnt <= '0;
         else if (restart_i || !run_i) dec_cnt <= '0;
         else if (us_tick)             dec_cnt <= dec_last ? '0 : dec_cnt + 1'b1;
      end

      // R1: a unit spans at least UNIT_US cycles, never two ticks in a row
      assert_unit_gap_R1 : assert property (@(posedge clk) disable iff (!rst_n)
         unit_tick_o |=> !unit_tick_o);
   end

endmodule

// File: rtl/ir_cap_sat_ctr.sv
module ir_cap_sat_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         inc_i,
   input  logic [W-1:0] limit_i,
   output logic [W-1:0] count_o,
   output logic         at_limit_o
);

   if (W < 2) begin : g_bad_w
      $error("ir_cap_sat_ctr: W must be at least 2");
   end

   assign at_limit_o = (count_o >= limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count_o <= '0;
      else if (clear_i)              count_o <= '0;
      else if (inc_i && !at_limit_o) count_o <= count_o + 1'b1;
   end

   // R6: once at the limit, further increments leave the count unchanged
   assert_sat_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && at_limit_o && !clear_i) |=> $stable(count_o));

endmodule

// File: rtl/ir_symbol_capture.sv
module ir_symbol_capture
   import ir_cap_pkg::*;
#(
   parameter int PRESCALE_W  = 7,
   parameter int UNIT_US     = 10,
   parameter int SYNC_STAGES = 2,
   parameter int BUSY_CYCLES = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_enable_i,
   input  logic                  cfg_raw_mode_i,
   input  logic                  cfg_format_i,
   input  logic [PRESCALE_W-1:0] cfg_prescale_i,
   input  logic [15:0]           cfg_max_width_i,
   input  logic                  start_i,
   input  logic                  ir_in_i,
   output logic                  busy_o,
   output logic                  sym_valid_o,
   output logic [31:0]           sym_word_o,
   output logic                  timeout_o
);

   localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
   localparam int SUM_W  = CNT_W + 1;

   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("ir_symbol_capture: BUSY_CYCLES must be at least 1");
   end
   if ($bits(sym_word_t) != 32) begin : g_bad_word
      $error("ir_symbol_capture: symbol word must be 32 bits");
   end

   // ---------------- line conditioning ----------------
   logic line_sync;
   logic fmt_q;
   logic line_act;
   logic act_q;
   logic rise_act;
   logic fall_act;

   ir_cap_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ir_in_i),
      .q_o   (line_sync)
   );

   // active (pulse) level: low for format 0, high for format 1
   assign line_act = line_sync ^ ~fmt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= line_act;
   end

   assign rise_act = line_act & ~act_q;
   assign fall_act = ~line_act & act_q;

   // ---------------- control state ----------------
   cap_state_e          state_q, state_d;
   logic [BUSY_W-1:0]   busy_cnt_q, busy_cnt_d;
   logic                fmt_d;

   logic                unit_tick;
   logic                tb_run;
   logic                tb_restart;
   cnt_t                mark_cnt, space_cnt;
   logic                mark_full, space_full;
   logic                mark_clr, space_clr;
   logic                mark_inc, space_inc;
   logic [SUM_W-1:0]    phase_sum;
   logic                sum_hit;
   logic                emit;
   logic                emit_to;
   sym_word_t           word_d;

   assign phase_sum = {1'b0, mark_cnt} + {1'b0, space_cnt};
   assign sum_hit   = (phase_sum >= {1'b0, cfg_max_width_i});

   always_comb begin
      state_d    = state_q;
      busy_cnt_d = busy_cnt_q;
      fmt_d      = fmt_q;
      emit       = 1'b0;
      emit_to    = 1'b0;
      mark_clr   = 1'b0;
      space_clr  = 1'b0;
      if (!cfg_enable_i) begin
         state_d = ST_OFF;
      end else begin
         unique case (state_q)
            ST_OFF: begin
               state_d    = ST_BUSY;
               busy_cnt_d = BUSY_W'(BUSY_CYCLES - 1);
            end
            ST_BUSY: begin
               if (busy_cnt_q == '0) state_d = ST_READY;
               else                  busy_cnt_d = busy_cnt_q - 1'b1;
            end
            ST_READY: begin
               if (start_i && cfg_raw_mode_i) begin
                  fmt_d   = cfg_format_i;
                  state_d = ST_WAIT_IDLE;
               end
            end
            ST_WAIT_IDLE: begin
               if (!line_act) state_d = ST_WAIT_PULSE;
            end
            ST_WAIT_PULSE: begin
               if (rise_act) begin
                  mark_clr = 1'b1;
                  state_d  = ST_MARK;
               end
            end
            ST_MARK: begin
               if (fall_act) begin
                  space_clr = 1'b1;
                  state_d   = ST_SPACE;
               end
            end
            ST_SPACE: begin
               if (sum_hit) begin
                  emit    = 1'b1;
                  emit_to = 1'b1;
                  if (rise_act) begin
                     mark_clr = 1'b1;
                     state_d  = ST_MARK;
                  end else begin
                     state_d  = ST_WAIT_PULSE;
                  end
               end else if (rise_act) begin
                  emit     = 1'b1;
                  mark_clr = 1'b1;
                  state_d  = ST_MARK;
               end
            end
            default: state_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_OFF;
         busy_cnt_q <= '0;
         fmt_q      <= 1'b0;
      end else begin
         state_q    <= state_d;
         busy_cnt_q <= busy_cnt_d;
         fmt_q      <= fmt_d;
      end
   end

   assign busy_o = (state_q == ST_BUSY);

   // ---------------- measurement ----------------
   assign tb_run     = cfg_enable_i && (state_q == ST_MARK || state_q == ST_SPACE);
   assign tb_restart = mark_clr || space_clr;
   assign mark_inc   = (state_q == ST_MARK)  && unit_tick;
   assign space_inc  = (state_q == ST_SPACE) && unit_tick && !emit;

   ir_cap_timebase #(
      .PRESCALE_W (PRESCALE_W),
      .UNIT_US    (UNIT_US)
   ) u_timebase (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (tb_run),
      .restart_i   (tb_restart),
      .prescale_i  (cfg_prescale_i),
      .unit_tick_o (unit_tick)
   );

   ir_cap_sat_ctr #(.W(CNT_W)) u_mark_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (mark_clr),
      .inc_i      (mark_inc),
      .limit_i    (cfg_max_width_i),
      .count_o    (mark_cnt),
      .at_limit_o (mark_full)
   );

   ir_cap_sat_ctr #(.W(CNT_W)) u_space_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (space_clr),
      .inc_i      (space_inc),
      .limit_i    (cfg_max_width_i),
      .count_o    (space_cnt),
      .at_limit_o (space_full)
   );

   // ---------------- symbol output ----------------
   always_comb begin
      word_d.mark  = mark_full ? cfg_max_width_i : mark_cnt;
      word_d.space = emit_to ? sat_sub(cfg_max_width_i, mark_cnt) : space_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_valid_o <= 1'b0;
         timeout_o   <= 1'b0;
         sym_word_o  <= '0;
      end else begin
         sym_valid_o <= emit;
         timeout_o   <= emit_to;
         if (emit) sym_word_o <= word_d;
      end
   end

   // ---------------- assertions ----------------
   // R11: each symbol strobe lasts one cycle
   assert_single_strobe_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid_o |=> !sym_valid_o);

   // R5: a timeout always comes with a symbol whose phases add up to the maximum
   assert_timeout_sum_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (sym_valid_o &&
         ({1'b0, sym_word_o[15:0]} + {1'b0, sym_word_o[31:16]} == {1'b0, cfg_max_width_i})));

   // R6: a reported pulse never exceeds the maximum
   assert_mark_bound_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid_o |-> (sym_word_o[15:0] <= cfg_max_width_i));

   // R7: no symbol while settling
   assert_quiet_busy_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !sym_valid_o);

   // R9: a disabled block goes silent and idle
   assert_off_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable_i |=> (!sym_valid_o && !busy_o));

endmodule

// File: tb/ir_symbol_capture_tb.sv
`timescale 1ns/1ps
module ir_symbol_capture_tb;

   localparam int PW    = 7;
   localparam int UNIT  = 10;
   localparam int BUSYN = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, raw = 1'b1, fmt = 1'b0, start = 1'b0, ir = 1'b1;
   logic [PW-1:0] pre = '0;
   logic [15:0] maxw = 16'd40;
   logic        busy, vld, tout;
   logic [31:0] word;

   int n_checks = 0;
   int n_fail   = 0;
   int dbl_valid = 0;
   bit done = 0;

   logic [32:0] got_q[$];
   logic [32:0] exp_q[$];

   always #10 clk = ~clk;

   ir_symbol_capture #(
      .PRESCALE_W (PW), .UNIT_US (UNIT), .SYNC_STAGES (2), .BUSY_CYCLES (BUSYN)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .cfg_enable_i (en), .cfg_raw_mode_i (raw),
      .cfg_format_i (fmt), .cfg_prescale_i (pre), .cfg_max_width_i (maxw),
      .start_i (start), .ir_in_i (ir), .busy_o (busy), .sym_valid_o (vld),
      .sym_word_o (word), .timeout_o (tout)
   );

   logic prev_vld = 1'b0;
   always @(negedge clk) begin
      if (vld) got_q.push_back({tout, word});
      if (vld && prev_vld) dbl_valid++;
      prev_vld = vld;
   end

   task automatic chk(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int unit_cycles();
      return (int'(pre) + 1) * UNIT;
   endfunction

   function automatic logic [32:0] exp_word(input int m, input int s, input bit to);
      int mm;
      mm = (m > int'(maxw)) ? int'(maxw) : m;
      if (to) s = int'(maxw) - mm;
      return {to, 16'(s), 16'(mm)};
   endfunction

   task automatic hold(input bit active, input int len);
      ir = active ? fmt : ~fmt;
      repeat (len) @(posedge clk);
      #1;
   endtask

   task automatic strobe_start();
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic compare(input string req);
      chk({req, " count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         chk(req, got_q[i], exp_q[i]);
      got_q.delete();
      exp_q.delete();
   endtask

   // burst of n symbols with given unit widths; last ends in a timeout
   task automatic burst(input int n, input int ms[8], input int ss[8]);
      int u;
      u = unit_cycles();
      for (int i = 0; i < n; i++) begin
         hold(1'b1, ms[i] * u + u / 2);
         if (i < n - 1) begin
            hold(1'b0, ss[i] * u + u / 2);
            exp_q.push_back(exp_word(ms[i], ss[i], 1'b0));
         end else begin
            hold(1'b0, (int'(maxw) + 4) * u);
            exp_q.push_back(exp_word(ms[i], 0, 1'b1));
         end
      end
      hold(1'b0, 4);
   endtask

   task automatic enable_measure(input string req);
      int cnt;
      cnt = 0;
      en = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (busy) cnt++;
         else break;
      end
      chk(req, cnt, BUSYN);
      @(posedge clk); #1;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int ms[8];
      int ss[8];
      repeat (3) @(posedge clk); #1;
      // reset state (R9)
      chk("R9 reset busy", busy, 0);
      chk("R9 reset valid", vld, 0);
      rst_n = 1'b1;
      repeat (3) @(posedge clk); #1;
      chk("R9 disabled busy", busy, 0);

      // R7: busy length; start during busy ignored
      en = 1'b1;
      @(posedge clk); #1;
      chk("R7 busy after enable", busy, 1);
      strobe_start();
      repeat (BUSYN + 2) @(posedge clk); #1;
      chk("R7 busy cleared", busy, 0);
      hold(1'b1, 35); hold(1'b0, 50 * 10);
      compare("R7 start in busy ignored");
      en = 1'b0;
      repeat (2) @(posedge clk); #1;
      enable_measure("R7 busy cycles");

      // R8: no start, then start with raw mode off
      hold(1'b1, 35); hold(1'b0, 50 * 10);
      compare("R8 no start");
      raw = 1'b0;
      strobe_start();
      hold(1'b1, 35); hold(1'b0, 50 * 10);
      compare("R8 raw off start ignored");
      raw = 1'b1;

      // R1 R2 R4 R5: directed burst, format 0, prescale 0
      strobe_start();
      hold(1'b0, 5);
      ms = '{3, 1, 7, 0, 0, 0, 0, 0};
      ss = '{5, 2, 0, 0, 0, 0, 0, 0};
      burst(3, ms, ss);
      compare("R2 R4 R5 directed");

      // R6: stuck pulse saturates
      maxw = 16'd20;
      ms = '{50, 0, 0, 0, 0, 0, 0, 0};
      burst(1, ms, ss);
      compare("R6 pulse saturation");
      maxw = 16'd40;

      // R1: random bursts with varied prescale
      for (int b = 0; b < 8; b++) begin
         int n;
         pre = PW'($urandom_range(0, 2));
         n = $urandom_range(1, 4);
         for (int i = 0; i < 8; i++) begin
            ms[i] = $urandom_range(1, 8);
            ss[i] = $urandom_range(1, 8);
         end
         burst(n, ms, ss);
         compare("R1 random burst");
      end
      pre = '0;

      // R9: disable in the middle of a burst
      hold(1'b1, 35); hold(1'b0, 25);
      en = 1'b0;
      @(posedge clk); #1;
      @(negedge clk);
      chk("R9 busy low when off", busy, 0);
      hold(1'b1, 35); hold(1'b0, 50 * 10);
      compare("R9 disabled no symbols");

      // R3 R10: inverted polarity, start while line is in a pulse
      fmt = 1'b1;
      enable_measure("R7 busy on re-enable");
      ir = 1'b1;
      strobe_start();
      hold(1'b1, 45);
      hold(1'b0, 25);
      ms = '{4, 6, 0, 0, 0, 0, 0, 0};
      ss = '{3, 0, 0, 0, 0, 0, 0, 0};
      burst(2, ms, ss);
      compare("R3 R10 inverted partial pulse");
      for (int b = 0; b < 4; b++) begin
         int n;
         pre = PW'($urandom_range(0, 2));
         n = $urandom_range(1, 4);
         for (int i = 0; i < 8; i++) begin
            ms[i] = $urandom_range(1, 8);
            ss[i] = $urandom_range(1, 8);
         end
         burst(n, ms, ss);
         compare("R3 random inverted burst");
      end

      chk("R11 single-cycle strobe", dbl_valid, 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule